// File: doc/BRIEF.md
# Expansion ROM Window Decoder

This block is the device-side logic behind a PCI-style expansion ROM. It holds one 32-bit configuration register that carries the ROM's base address and a decode-enable flag. Address bits that fall inside the ROM's own size are hardwired to zero, so that firmware can find the ROM size by probing. Firmware writes ones to the address field, reads back the mask, picks an aligned base, and then sets the enable flag.

Once the window is live, the memory read port compares each request against the programmed base. It returns one 32-bit word of the internal ROM image one cycle later, together with a hit flag. A request is claimed only when the register's own enable flag and the command register's memory-space bit, which comes in as an input, are both set.

The ROM image is computed from parameters: a signature word, then a fill pattern. ROM_BYTES must be a power of two and at least 2048, and elaboration stops with an error otherwise.

Top module: `xrom_bar_decoder`

## Requirements
- R1: After reset, the window register reads 0 (enable clear, base zero), and no memory request is claimed until it is reprogrammed.
- R2: The register sits at configuration dword 12 (byte offset 30h) when BRIDGE_HDR is 0, and at dword 14 (byte offset 38h) when BRIDGE_HDR is 1. Every other dword reads 0, and writes to other dwords leave the register unchanged.
- R3: Bit 0 is the decode enable. It stores the written value and reads it back, and while it is 0 no request is claimed.
- R4: Bits 31 down to log2(ROM_BYTES) store the written base. Bits log2(ROM_BYTES)-1 down to 1 always read 0. With the default 4096-byte ROM, writing FFFF_F800h reads back FFFF_F000h.
- R5: A request is claimed only if all three of these hold: the enable bit is 1, cmd_mem_en is 1, and mem_addr[31:log2(ROM_BYTES)] equals the stored base.
- R6: mem_hit and mem_rdata are registered and appear on the cycle after mem_req. On a miss or with no request, mem_hit is 0 and mem_rdata is 0.
- R7: Word 0 of the ROM holds byte 0 = 55h, byte 1 = AAh (AA55h little-endian), byte 2 = ROM_BYTES/512, and byte 3 = 00h. Word i ≥ 1 holds {FILL_SEED ^ i[15:0], ~i[15:0]}.
- R8: The word index is mem_addr[log2(ROM_BYTES)-1:2], and mem_addr[1:0] has no effect on the data returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from cfg_dw |
| cmd_mem_en | input | 1 | Memory-space enable bit of the command register |
| mem_req | input | 1 | Memory read request |
| mem_addr | input | 32 | Memory read byte address |
| mem_rdata | output | 32 | ROM word, one cycle after the request |
| mem_hit | output | 1 | Request claimed, one cycle after the request |

## Verification
The properties assume that mem_req, mem_addr and cmd_mem_en are sampled at the same edge that registers the result. They also assume these inputs are held at defined values from time zero. The bench meets this by driving every input on the falling edge, and by holding mem_req low during reset.

The gating property compares the hit with the values of the previous cycle, and a register write in that cycle would upset that comparison. For that reason, no test issues a configuration write in the same cycle as a memory request.

// File: rtl/xrom_bar_decoder.sv
module xrom_bar_decoder #(
  parameter int          ROM_BYTES  = 4096,
  parameter bit          BRIDGE_HDR = 1'b0,
  parameter logic [15:0] FILL_SEED  = 16'h5EED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_dw,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cmd_mem_en,
  input  logic        mem_req,
  input  logic [31:0] mem_addr,
  output logic [31:0] mem_rdata,
  output logic        mem_hit
);
  localparam int         SZ     = $clog2(ROM_BYTES);
  localparam int         WIDX   = SZ - 2;
  localparam int         BLOCKS = ROM_BYTES / 512;
  localparam logic [5:0] BAR_DW = BRIDGE_HDR ? 6'd14 : 6'd12;

  generate
    if (ROM_BYTES < 2048 || (ROM_BYTES & (ROM_BYTES - 1)) != 0) begin : g_bad_size
      $error("ROM_BYTES must be a power of two of at least 2048");
    end
  endgenerate

  logic [31-SZ:0] base_q;
  logic           en_q;
  logic           sel;
  logic           hit_d;
  logic           unused_ok;

  assign sel = (cfg_dw == BAR_DW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we && sel) begin
      base_q <= cfg_wdata[31:SZ];
      en_q   <= cfg_wdata[0];
    end
  end

  assign cfg_rdata = sel ? {base_q, {(SZ-1){1'b0}}, en_q} : 32'h0;

  assign hit_d = mem_req && en_q && cmd_mem_en && (mem_addr[31:SZ] == base_q);

  function automatic logic [31:0] rom_word(input logic [WIDX-1:0] idx);
    logic [15:0] i16;
    i16 = 16'(idx);
    if (idx == '0) return {8'h00, 8'(BLOCKS), 8'hAA, 8'h55};
    return {FILL_SEED ^ i16, ~i16};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_hit   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_hit   <= hit_d;
      mem_rdata <= hit_d ? rom_word(mem_addr[SZ-1:2]) : 32'h0;
    end
  end

  assign unused_ok = ^{mem_addr[1:0], cfg_wdata[SZ-1:1]};
endmodule

// File: rtl/xrom_bar_decoder_chk.sv
module xrom_bar_decoder_chk #(
  parameter int         SZ     = 12,
  parameter logic [5:0] BAR_DW = 6'd12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    cfg_dw,
  input logic [31:0]   cfg_rdata,
  input logic          cmd_mem_en,
  input logic          mem_req,
  input logic [31:0]   mem_addr,
  input logic [31:0]   mem_rdata,
  input logic          mem_hit,
  input logic [31-SZ:0] base_q,
  input logic          en_q
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (base_q == '0 && !en_q && !mem_hit));

  a_r2_other_dw_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw != BAR_DW) |-> (cfg_rdata == 32'h0));

  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[SZ-1:1] == '0);

  a_r5_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> $past(mem_req && en_q && cmd_mem_en && (mem_addr[31:SZ] == base_q)));

  a_r3_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $stable(en_q)) |=> !mem_hit);

  a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> (mem_rdata == 32'h0));

  a_r6_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> !mem_hit);
endmodule

bind xrom_bar_decoder xrom_bar_decoder_chk #(.SZ(SZ), .BAR_DW(BAR_DW)) u_chk (.*);

// File: tb/xrom_bar_decoder_test.sv
`timescale 1ns/1ps
module xrom_bar_decoder_test;
  localparam int          ROM_BYTES = 4096;
  localparam int          SZ        = $clog2(ROM_BYTES);
  localparam logic [15:0] SEED      = 16'h5EED;
  localparam logic [31:0] BASE      = 32'h8000_0000;
  localparam int          NV        = 9;
  // {cmd_mem_en, addr, expected hit}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 32'h8000_0000, 1'b1},
    {1'b1, 32'h8000_0004, 1'b1},
    {1'b1, 32'h8000_0FFC, 1'b1},
    {1'b1, 32'h8000_0007, 1'b1},
    {1'b1, 32'h8000_1000, 1'b0},
    {1'b1, 32'h7FFF_FFFC, 1'b0},
    {1'b0, 32'h8000_0010, 1'b0},
    {1'b1, 32'h0000_0010, 1'b0},
    {1'b1, 32'h8000_0800, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_dw = 6'd0;
  logic [31:0] cfg_wdata = 32'h0;
  logic cmd_mem_en = 1'b0;
  logic mem_req = 1'b0;
  logic [31:0] mem_addr = 32'h0;
  logic [31:0] cfg_rdata, cfg_rdata_b, mem_rdata, mem_rdata_b;
  logic mem_hit, mem_hit_b;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xrom_bar_decoder #(.ROM_BYTES(ROM_BYTES), .BRIDGE_HDR(1'b0), .FILL_SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_mem_en(cmd_mem_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit));

  xrom_bar_decoder #(.ROM_BYTES(ROM_BYTES), .BRIDGE_HDR(1'b1), .FILL_SEED(SEED)) uut_br (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata_b), .cmd_mem_en(cmd_mem_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata_b), .mem_hit(mem_hit_b));

  function automatic logic [31:0] model_word(input logic [31:0] addr);
    logic [15:0] i;
    i = 16'(addr[SZ-1:2]);
    if (i == 16'h0) return {8'h00, 8'(ROM_BYTES / 512), 8'hAA, 8'h55};
    return {SEED ^ i, ~i};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = dw; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d, output logic [31:0] db);
    @(negedge clk);
    cfg_dw = dw;
    #1;
    d = cfg_rdata;
    db = cfg_rdata_b;
  endtask

  task automatic mem_read(input logic cmd, input logic [31:0] a);
    @(negedge clk);
    mem_req = 1'b1; mem_addr = a; cmd_mem_en = cmd;
    @(negedge clk);
    mem_req = 1'b0;
  endtask

  initial begin
    logic [31:0] r, rb;
    logic [31:0] ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cfg_read(6'd12, r, rb);
    check("R1 reset register", r, 32'h0);
    mem_read(1'b1, 32'h0000_0000);
    check("R1 no hit after reset", {31'h0, mem_hit}, 32'h0);

    cfg_write(6'd12, 32'hFFFF_F800);
    cfg_read(6'd12, r, rb);
    check("R4 size probe mask", r, 32'hFFFF_F000);
    cfg_write(6'd12, 32'hFFFF_FFFF);
    cfg_read(6'd12, r, rb);
    check("R3 enable readback", r, 32'hFFFF_F001);

    cfg_write(6'd12, BASE | 32'h1);
    cfg_read(6'd12, r, rb);
    check("R3 base plus enable", r, 32'h8000_0001);

    for (int k = 0; k < NV; k++) begin
      mem_read(VEC[k][33], VEC[k][32:1]);
      ev = VEC[k][0] ? model_word(VEC[k][32:1]) : 32'h0;
      check("R5 hit flag", {31'h0, mem_hit}, {31'h0, VEC[k][0]});
      check("R6/R7/R8 read data", mem_rdata, ev);
    end

    mem_read(1'b1, BASE);
    check("R7 signature AA55", {16'h0, mem_rdata[15:0]}, 32'h0000_AA55);
    check("R7 size byte", {24'h0, mem_rdata[23:16]}, ROM_BYTES / 512);

    mem_read(1'b1, BASE + 32'h8);
    check("R8 word 2", mem_rdata, model_word(32'h8));
    mem_read(1'b1, BASE + 32'hB);
    check("R8 low bits ignored", mem_rdata, model_word(32'h8));

    cfg_write(6'd14, 32'hC000_0001);
    cfg_read(6'd14, r, rb);
    check("R2 endpoint ignores dword 14", r, 32'h0);
    check("R2 bridge at dword 14", rb, 32'hC000_0001);
    cfg_read(6'd12, r, rb);
    check("R2 endpoint register unchanged", r, 32'h8000_0001);
    check("R2 bridge dword 12 reads zero", rb, 32'h0);
    mem_read(1'b1, 32'hC000_0010);
    check("R2 bridge window hit", {31'h0, mem_hit_b}, 32'h1);
    check("R2 bridge data", mem_rdata_b, model_word(32'h10));
    check("R5 endpoint misses other base", {31'h0, mem_hit}, 32'h0);

    cfg_write(6'd12, BASE);
    mem_read(1'b1, BASE + 32'h4);
    check("R3 disabled no hit", {31'h0, mem_hit}, 32'h0);
    check("R6 miss data zero", mem_rdata, 32'h0);

    cfg_write(6'd12, BASE | 32'h1);
    @(negedge clk);
    mem_req = 1'b1; mem_addr = BASE + 32'h4; cmd_mem_en = 1'b1;
    #1;
    check("R6 no combinational hit", {31'h0, mem_hit}, 32'h0);
    @(negedge clk);
    mem_req = 1'b0;
    check("R6 hit after one cycle", {31'h0, mem_hit}, 32'h1);
    @(negedge clk);
    check("R6 hit drops without request", {31'h0, mem_hit}, 32'h0);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_read(6'd12, r, rb);
    check("R1 register cleared by reset", r, 32'h0);
    mem_read(1'b1, BASE);
    check("R1 no hit after second reset", {31'h0, mem_hit}, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule